// File: doc/BRIEF.md
# Dual-Direction Pipelined Byte Substitution Unit

This block performs the AES byte substitution in either direction on one byte per clock. A direction bit that comes with each byte selects the forward S-box or its inverse. No lookup table is used. The multiplicative inverse in GF(2^8), reduced by x^8 + x^4 + x^3 + x + 1, is worked out in a composite field GF((2^4)^2). A linear change of basis maps the byte into that field, and the inverse change maps it back. One inverse circuit serves both directions. The affine step is applied after the inverse for forward substitution. The inverse affine step is applied before the inverse for reverse substitution.

The logic is split into three registered sub-stages so that it can sit inside a sub-pipelined cipher round. Stage one holds the input affine step and the basis change. Stage two computes the norm of the composite element and its inverse in GF(2^4). Stage three finishes the two sub-field products, maps back to the standard basis and applies the output affine step. The direction bit and the valid flag move through the same registers as the data. A stream may therefore change direction on any byte. The basis-change matrices are derived from the field polynomials when the design is elaborated, so no hand-entered constants are involved.

Top module: `sbox_dual_pipe`

## Requirements
- R1: With `in_inv` = 0, the output byte is the multiplicative inverse of the input (zero maps to zero), followed by the affine transform that XORs the byte with its left rotations by 1, 2, 3 and 4 bits and then with 0x63. This holds for all 256 input values.
- R2: With `in_inv` = 1, the output byte comes from the inverse affine transform followed by the multiplicative inverse. The inverse affine transform XORs the input with 0x63 and then XORs the left rotations of that result by 1, 3 and 6 bits. This holds for all 256 input values.
- R3: The zero corner cases follow from treating the inverse of 0x00 as 0x00. In the forward direction, 0x00 gives 0x63. In the inverse direction, 0x63 gives 0x00.
- R4: A byte accepted at a rising edge appears on `out_byte` after the third rising edge, counting that edge. A new byte is accepted on every cycle.
- R5: The direction is taken per byte. Bytes of alternating direction presented back to back each come out with their own direction's result.
- R6: `out_vld` equals `in_vld` delayed by exactly three cycles, so gaps in the input stream reappear as low `out_vld` cycles at the output.
- R7: While `rst` is high, the cycle after it `out_vld` is 0, and bytes in flight at reset are discarded.
- R8: Forward 0x53 gives 0xED, and inverse 0xED gives 0x53.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input byte valid |
| in_inv | input | 1 | Direction: 0 = forward substitution, 1 = inverse substitution |
| in_byte | input | 8 | Byte to substitute |
| out_vld | output | 1 | Output byte valid, three cycles after the input |
| out_byte | output | 8 | Substituted byte |

## Verification
Every result is due three rising edges after its byte is driven. The bench drives inputs on falling edges. It keeps a three-deep model of expected valid flags, bytes and requirement tags that shifts once per cycle. On each falling edge it compares the ports with the oldest entry, so both the latency and the value are checked on every cycle, including idle ones. The expected bytes come from a table built inside the bench by GF(2^8) exponentiation and a bit-level affine step, and the inverse table is the forward table inverted. A reset in the middle of a stream clears the model, and the bench then checks that nothing in flight emerges.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int BYTE_W     = 8;
  localparam int NIB_W      = 4;
  localparam int PIPE_DEPTH = 3;
  localparam logic [BYTE_W-1:0] AFF_CONST = 8'h63;
  localparam logic [BYTE_W-1:0] BYTE_RED  = 8'h1B;  // x^8 = x^4+x^3+x+1
  localparam logic [NIB_W-1:0]  NIB_RED   = 4'h3;   // z^4 = z+1

  typedef struct packed {
    logic vld;
    logic inv;
  } ctl_t;

  function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] x, input int n);
    logic [2*BYTE_W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*BYTE_W-1:BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] gf8_mul(input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] p;
    logic [BYTE_W-1:0] t;
    p = '0;
    t = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) p = p ^ t;
      t = {t[BYTE_W-2:0], 1'b0} ^ (t[BYTE_W-1] ? BYTE_RED : '0);
    end
    return p;
  endfunction

  function automatic logic [NIB_W-1:0] gf4_mul(input logic [NIB_W-1:0] a, input logic [NIB_W-1:0] b);
    logic [NIB_W-1:0] p;
    logic [NIB_W-1:0] t;
    p = '0;
    t = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) p = p ^ t;
      t = {t[NIB_W-2:0], 1'b0} ^ (t[NIB_W-1] ? NIB_RED : '0);
    end
    return p;
  endfunction

  // a^14 = a^-1 in GF(16); zero stays zero
  function automatic logic [NIB_W-1:0] gf4_inv(input logic [NIB_W-1:0] a);
    logic [NIB_W-1:0] a2, a4, a8;
    a2 = gf4_mul(a, a);
    a4 = gf4_mul(a2, a2);
    a8 = gf4_mul(a4, a4);
    return gf4_mul(gf4_mul(a2, a4), a8);
  endfunction

  // smallest nu with y^2 + y + nu irreducible over GF(16)
  function automatic logic [NIB_W-1:0] find_nu();
    logic [NIB_W-1:0] res;
    logic hit;
    res = '0;
    for (int n = 15; n >= 1; n--) begin
      hit = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((gf4_mul(NIB_W'(t), NIB_W'(t)) ^ NIB_W'(t)) == NIB_W'(n)) hit = 1'b1;
      if (!hit) res = NIB_W'(n);
    end
    return res;
  endfunction

  // a root of z^4 + z + 1 inside GF(256)
  function automatic logic [BYTE_W-1:0] find_alpha();
    logic [BYTE_W-1:0] res;
    logic [BYTE_W-1:0] a2;
    res = '0;
    for (int a = 255; a >= 2; a--) begin
      a2 = gf8_mul(BYTE_W'(a), BYTE_W'(a));
      if ((gf8_mul(a2, a2) ^ BYTE_W'(a) ^ 8'h01) == '0) res = BYTE_W'(a);
    end
    return res;
  endfunction

  function automatic logic [BYTE_W-1:0] embed_nib(input logic [NIB_W-1:0] x, input logic [BYTE_W-1:0] alpha);
    logic [BYTE_W-1:0] pw;
    logic [BYTE_W-1:0] s;
    pw = 8'h01;
    s  = '0;
    for (int i = 0; i < NIB_W; i++) begin
      if (x[i]) s = s ^ pw;
      pw = gf8_mul(pw, alpha);
    end
    return s;
  endfunction

  function automatic logic [BYTE_W-1:0] find_beta(input logic [BYTE_W-1:0] nu_img);
    logic [BYTE_W-1:0] res;
    res = '0;
    for (int b = 255; b >= 1; b--)
      if ((gf8_mul(BYTE_W'(b), BYTE_W'(b)) ^ BYTE_W'(b)) == nu_img) res = BYTE_W'(b);
    return res;
  endfunction

  function automatic logic [BYTE_W*BYTE_W-1:0] apply_cols_dummy();
    return '0;
  endfunction

  function automatic logic [BYTE_W-1:0] apply_cols(input logic [BYTE_W*BYTE_W-1:0] cols,
                                                   input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] s;
    s = '0;
    for (int k = 0; k < BYTE_W; k++)
      if (x[k]) s = s ^ cols[k*BYTE_W +: BYTE_W];
    return s;
  endfunction

  // composite {h,l} -> standard basis: l bits weigh alpha^i, h bits alpha^i*beta
  function automatic logic [BYTE_W*BYTE_W-1:0] build_c2s();
    logic [BYTE_W*BYTE_W-1:0] cols;
    logic [BYTE_W-1:0] alpha, beta, pw;
    alpha = find_alpha();
    beta  = find_beta(embed_nib(find_nu(), alpha));
    pw    = 8'h01;
    cols  = '0;
    for (int i = 0; i < NIB_W; i++) begin
      cols[i*BYTE_W +: BYTE_W]         = pw;
      cols[(i+NIB_W)*BYTE_W +: BYTE_W] = gf8_mul(pw, beta);
      pw = gf8_mul(pw, alpha);
    end
    return cols;
  endfunction

  function automatic logic [BYTE_W*BYTE_W-1:0] build_s2c(input logic [BYTE_W*BYTE_W-1:0] c2s);
    logic [BYTE_W*BYTE_W-1:0] cols;
    cols = '0;
    for (int k = 0; k < BYTE_W; k++)
      for (int c = 0; c < 256; c++)
        if (apply_cols(c2s, BYTE_W'(c)) == (BYTE_W'(1) << k)) cols[k*BYTE_W +: BYTE_W] = BYTE_W'(c);
    return cols;
  endfunction

  localparam logic [NIB_W-1:0]         NORM_NU  = find_nu();
  localparam logic [BYTE_W*BYTE_W-1:0] C2S_COLS = build_c2s();
  localparam logic [BYTE_W*BYTE_W-1:0] S2C_COLS = build_s2c(C2S_COLS);

endpackage

// File: rtl/sbox_affine.sv
module sbox_affine
  import sbox_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  generate
    if (INVERSE) begin : g_inv
      // R2: strip the constant, then rotate-XOR by 1, 3, 6
      logic [BYTE_W-1:0] unc;
      always_comb begin
        unc  = din ^ AFF_CONST;
        dout = rotl8(unc, 1) ^ rotl8(unc, 3) ^ rotl8(unc, 6);
      end
    end else begin : g_fwd
      // R1: rotate-XOR by 0..4, then add the constant
      always_comb
        dout = din ^ rotl8(din, 1) ^ rotl8(din, 2) ^ rotl8(din, 3) ^ rotl8(din, 4) ^ AFF_CONST;
    end
  endgenerate
endmodule

// File: rtl/sbox_field_map.sv
module sbox_field_map
  import sbox_pkg::*;
#(
  parameter bit TO_COMPOSITE = 1'b1
) (
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  localparam logic [BYTE_W*BYTE_W-1:0] COLS = TO_COMPOSITE ? S2C_COLS : C2S_COLS;

  always_comb begin
    dout = '0;
    for (int k = 0; k < BYTE_W; k++)
      if (din[k]) dout = dout ^ COLS[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/sbox_norm_inv.sv
module sbox_norm_inv
  import sbox_pkg::*;
(
  input  logic [NIB_W-1:0] hi,
  input  logic [NIB_W-1:0] lo,
  output logic [NIB_W-1:0] norm_inv
);
  logic [NIB_W-1:0] norm;

  // (h*y + l) * (h*y + h + l) = h^2*nu + h*l + l^2 for y^2 = y + nu
  always_comb begin
    norm     = gf4_mul(gf4_mul(hi, hi), NORM_NU) ^ gf4_mul(hi, lo) ^ gf4_mul(lo, lo);
    norm_inv = gf4_inv(norm);
  end
endmodule

// File: rtl/sbox_dual_pipe.sv
module sbox_dual_pipe
  import sbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_inv,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_vld,
  output logic [BYTE_W-1:0] out_byte
);

  // ---------------- stage 1: input affine + basis change ----------------
  logic [BYTE_W-1:0] pre_unaff, pre_sel, pre_comp;
  ctl_t              s1_ctl;
  logic [BYTE_W-1:0] s1_comp;

  sbox_affine #(.INVERSE(1'b1)) u_in_aff (.din(in_byte), .dout(pre_unaff));

  always_comb pre_sel = in_inv ? pre_unaff : in_byte;

  sbox_field_map #(.TO_COMPOSITE(1'b1)) u_to_comp (.din(pre_sel), .dout(pre_comp));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_ctl  <= '0;
      s1_comp <= '0;
    end else begin
      s1_ctl  <= '{vld: in_vld, inv: in_inv};
      s1_comp <= pre_comp;
    end
  end

  // ---------------- stage 2: norm and its GF(16) inverse -----------------
  logic [NIB_W-1:0] nrm_inv;
  ctl_t             s2_ctl;
  logic [NIB_W-1:0] s2_hi, s2_lo, s2_ninv;

  sbox_norm_inv u_norm (
    .hi      (s1_comp[BYTE_W-1:NIB_W]),
    .lo      (s1_comp[NIB_W-1:0]),
    .norm_inv(nrm_inv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_ctl  <= '0;
      s2_hi   <= '0;
      s2_lo   <= '0;
      s2_ninv <= '0;
    end else begin
      s2_ctl  <= s1_ctl;
      s2_hi   <= s1_comp[BYTE_W-1:NIB_W];
      s2_lo   <= s1_comp[NIB_W-1:0];
      s2_ninv <= nrm_inv;
    end
  end

  // -------- stage 3: finish inverse, map back, output affine --------
  logic [NIB_W-1:0]  inv_hi, inv_lo;
  logic [BYTE_W-1:0] back_std, back_aff, post_sel;

  always_comb begin
    inv_hi = gf4_mul(s2_hi, s2_ninv);
    inv_lo = gf4_mul(s2_hi ^ s2_lo, s2_ninv);
  end

  sbox_field_map #(.TO_COMPOSITE(1'b0)) u_to_std (.din({inv_hi, inv_lo}), .dout(back_std));
  sbox_affine    #(.INVERSE(1'b0))      u_out_aff (.din(back_std), .dout(back_aff));

  always_comb post_sel = s2_ctl.inv ? back_std : back_aff;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_byte <= '0;
    end else begin
      out_vld  <= s2_ctl.vld;
      out_byte <= post_sel;
    end
  end

  // ---------------- assertions ----------------
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_valid_delay_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_vld == $past(in_vld, PIPE_DEPTH)));

  assert_fwd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(in_vld, PIPE_DEPTH) && !$past(in_inv, PIPE_DEPTH)
     && $past(in_byte, PIPE_DEPTH) == 8'h00) |-> (out_byte == 8'h63));

  assert_inv_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(in_vld, PIPE_DEPTH) && $past(in_inv, PIPE_DEPTH)
     && $past(in_byte, PIPE_DEPTH) == 8'h63) |-> (out_byte == 8'h00));

  assert_fwd_53_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(in_vld, PIPE_DEPTH) && !$past(in_inv, PIPE_DEPTH)
     && $past(in_byte, PIPE_DEPTH) == 8'h53) |-> (out_byte == 8'hED));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> !out_vld);

endmodule

// File: tb/sbox_dual_pipe_test.sv
module sbox_dual_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic       in_inv = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_vld;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbox_dual_pipe uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_inv(in_inv),
    .in_byte(in_byte), .out_vld(out_vld), .out_byte(out_byte)
  );

  logic [7:0] fwd_tbl [256];
  logic [7:0] inv_tbl [256];

  function automatic logic [7:0] mul8(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= t;
      t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_fwd(input logic [7:0] x);
    logic [7:0] r = 8'h01;
    logic [7:0] y;
    for (int i = 0; i < 254; i++) r = mul8(r, x);  // x^254, zero stays zero
    for (int i = 0; i < 8; i++)
      y[i] = r[i] ^ r[(i+4)%8] ^ r[(i+5)%8] ^ r[(i+6)%8] ^ r[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
    return y;
  endfunction

  // expected-result model, three deep
  logic       pv [3];
  logic [7:0] pd [3];
  string      pt [3];

  task automatic clear_model();
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pd[i] = 8'h00; pt[i] = "R6"; end
  endtask

  task automatic step(input logic v, input logic m, input logic [7:0] d, input string tag);
    @(negedge clk);
    checks++;
    if (out_vld !== pv[2]) begin
      errors++;
      $display("FAIL %s/R6: out_vld=%0b expected %0b", pt[2], out_vld, pv[2]);
    end
    if (pv[2]) begin
      checks++;
      if (out_byte !== pd[2]) begin
        errors++;
        $display("FAIL %s: out_byte=%02h expected %02h", pt[2], out_byte, pd[2]);
      end
    end
    pv[2] = pv[1]; pd[2] = pd[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
    pv[0] = v; pd[0] = m ? inv_tbl[d] : fwd_tbl[d]; pt[0] = tag;
    in_vld = v; in_inv = m; in_byte = d;
  endtask

  task automatic check_quiet(input string tag);
    checks++;
    if (out_vld !== 1'b0) begin
      errors++;
      $display("FAIL %s: out_vld=%0b expected 0", tag, out_vld);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) fwd_tbl[i] = ref_fwd(8'(i));
    for (int i = 0; i < 256; i++) inv_tbl[fwd_tbl[i]] = 8'(i);
    clear_model();

    // R7: quiet while in reset
    repeat (3) begin @(negedge clk); check_quiet("R7"); end
    rst = 1'b0;

    // R1 / R3 / R8: forward sweep, back to back
    for (int i = 0; i < 256; i++)
      step(1'b1, 1'b0, 8'(i), (i == 0) ? "R3" : (i == 8'h53) ? "R8" : "R1");
    // R2 / R3 / R8: inverse sweep
    for (int i = 0; i < 256; i++)
      step(1'b1, 1'b1, 8'(i), (i == 8'h63) ? "R3" : (i == 8'hED) ? "R8" : "R2");
    // R5 / R6: alternating direction with gaps
    for (int i = 0; i < 256; i++)
      step((i % 5) != 0, i[0], 8'(i * 7 + 3), "R5");
    // R4: isolated bytes, output only on the third edge
    for (int k = 0; k < 4; k++) begin
      step(1'b1, k[0], 8'(8'h53 + k), "R4");
      step(1'b0, 1'b0, 8'h00, "R4");
      step(1'b0, 1'b0, 8'h00, "R4");
    end
    repeat (3) step(1'b0, 1'b0, 8'h00, "R6");

    // R7: reset in mid-stream drops bytes in flight
    step(1'b1, 1'b0, 8'h11, "R7");
    step(1'b1, 1'b1, 8'h22, "R7");
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0;
    @(negedge clk); check_quiet("R7");
    @(negedge clk); check_quiet("R7");
    rst = 1'b0;
    clear_model();
    repeat (4) step(1'b0, 1'b0, 8'h00, "R7");
    step(1'b1, 1'b0, 8'h00, "R3");
    repeat (3) step(1'b0, 1'b0, 8'h00, "R6");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule